// File: doc/BRIEF.md
# Fractional-N Divide Value Sequencer

This block decides, once per phase-detector reference period, which whole divide value the feedback counter chain should use next, so that the long-run average of those values equals an integer part plus a fraction expressed as numerator over modulus. An accumulator advances by the numerator on each reference tick and wraps at the modulus. A wrap raises a carry, and the divide value for that period becomes the integer part plus one. In the spur-optimised setting, a pseudo-random bit is added to the accumulator input and then taken back out on the following tick. This breaks up periodic carry patterns without moving the average.

The integer part, numerator, modulus and noise mode are sampled only on a reference tick. Changes between ticks therefore never disturb the period already running. A numerator above the modulus is replaced by the modulus, and the substitution is flagged. A counter-reset input and a power-down input hold the accumulator in its load state. They differ in what happens to the dither generator.

The control is a three-state machine that is re-evaluated on every clock edge:

- **HOLD**: entered while counter reset is high and power-down is low. It is also the state after the asynchronous reset.
- **OFF**: entered whenever power-down is high. Power-down takes priority over counter reset.
- **RUN**: entered when both inputs are low.

The transitions are:

| Transition | Cause |
|---|---|
| RUN→HOLD | reset asserted |
| RUN→OFF | power-down asserted |
| HOLD→OFF | power-down asserted |
| OFF→HOLD | power-down dropped while reset is still high |
| HOLD→RUN, OFF→RUN | release |
| RUN→RUN | steady operation |

Top module: `fnd_modulus_ctrl`

## Requirements
- R1: After the asynchronous reset, `div_val`, `carry` and `frac_err` are 0 and the dither generator holds the value 1.
- R2: `div_val` always equals the most recently captured integer part plus `carry`, as a 9-bit unsigned value.
- R3: On a reference tick in RUN, with dither off, the sum of the accumulator and the numerator is formed. If that sum is at least the modulus, the modulus is subtracted and `carry` becomes 1; otherwise `carry` is 0. For a fixed setting, the carries over MOD ticks number exactly FRAC.
- R4: Integer part, numerator, modulus and mode are captured only on an edge where `ref_tick` is 1. Between ticks, with neither hold input high, `div_val`, `carry` and `frac_err` do not change.
- R5: A numerator greater than the modulus at a tick is used as equal to the modulus, and `frac_err` is set to 1. A later tick with a legal numerator clears `frac_err`.
- R6: Dither is on only in mode 3'b000 and only when 0 < FRAC < MOD. It uses bit 0 of a 15-bit shift register that moves left on each RUN tick and takes in bit14 XOR bit13. That bit is added to the sum on its own tick and subtracted on the next tick.
- R7: In every mode other than 3'b000 (including 3'b001 and 3'b111), no dither bit is added. The subtraction of a bit still pending from an earlier tick still takes place.
- R8: While `cnt_rst` is high and `pwr_dn` is low, the accumulator and the pending dither bit are 0, `carry` is 0, and the dither register is reloaded with 1.
- R9: While `pwr_dn` is high, the accumulator, the pending bit and `carry` are 0, and the dither register keeps its value. `pwr_dn` has priority over `cnt_rst`.
- R10: Accumulation applies only on an edge that has both the previous and the current state at RUN. A tick on the edge that releases HOLD or OFF captures the settings but does not advance.
- R11: With a modulus of 0, `carry` stays 0. An accumulator value left at or above a newly captured modulus is treated as 0. A sum that the pending subtraction would drive below 0 is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle pulse marking the start of a reference period |
| int_val | input | 8 | Integer part of the division |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus |
| noise_mode | input | 3 | Noise/spur mode; 3'b000 enables dither |
| cnt_rst | input | 1 | Hold the counters in reset |
| pwr_dn | input | 1 | Power-down; forces the load state |
| div_val | output | 9 | Divide value for the current period |
| carry | output | 1 | Accumulator wrap in the current period |
| frac_err | output | 1 | Captured numerator exceeded the modulus |

## Verification
Every result of this block is registered once. A tick or a hold input present at a rising edge shows up on `div_val`, `carry` and `frac_err` directly after that edge, and nothing depends on the input values between edges. A behavioural model in the bench applies the same rule at each rising edge, and the outputs are compared with it at the following falling edge. The model tracks the previous-state condition of R10, so a tick on a release edge is expected to leave the accumulator alone. The directed carry counts are read at the falling edge that follows each tick edge.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_OFF  = 2'd2
    } fnd_state_e;

    localparam logic [2:0] MODE_LOW_SPUR = 3'b000;
endpackage

// File: rtl/fnd_shadow.sv
module fnd_shadow #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  int_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [FRAC_W-1:0] mod_in,
    output logic [FRAC_W-1:0] frac_clamped,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] mod_q,
    output logic              err_q
);
    logic over;

    always_comb begin
        over         = (frac_in > mod_in);
        frac_clamped = over ? mod_in : frac_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
            mod_q <= '0;
            err_q <= 1'b0;
        end else if (load) begin
            int_q <= int_in;
            mod_q <= mod_in;
            err_q <= over;
        end
    end
endmodule

// File: rtl/fnd_lfsr.sv
module fnd_lfsr #(
    parameter int W     = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic advance,
    output logic bit_o
);
    localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sr_q;
    logic         fb;

    assign fb    = sr_q[TAP_A] ^ sr_q[TAP_B];
    assign bit_o = sr_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else if (reseed) begin
            sr_q <= SEED;
        end else if (advance) begin
            sr_q <= {sr_q[W-2:0], fb};
        end
    end
endmodule

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    input  logic [FRAC_W-1:0] modulus,
    input  logic              dith,
    output logic              carry_o,
    output logic              pend_o
);
    localparam int SUM_W = FRAC_W + 2;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] base;
    logic [SUM_W-1:0]  raw;
    logic [SUM_W-1:0]  net;
    logic [SUM_W-1:0]  mod_x;
    logic              wrap;
    logic [SUM_W-1:0]  nxt;

    always_comb begin
        base  = (acc_q >= modulus) ? '0 : acc_q;
        raw   = SUM_W'(base) + SUM_W'(frac) + SUM_W'(dith);
        net   = (raw < SUM_W'(pend_o)) ? '0 : raw - SUM_W'(pend_o);
        mod_x = SUM_W'(modulus);
        wrap  = (modulus != '0) && (net >= mod_x);
        nxt   = wrap ? net - mod_x : net;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_o <= 1'b0;
            pend_o  <= 1'b0;
        end else if (clear) begin
            acc_q   <= '0;
            carry_o <= 1'b0;
            pend_o  <= 1'b0;
        end else if (step) begin
            acc_q   <= nxt[FRAC_W-1:0];
            carry_o <= wrap;
            pend_o  <= dith;
        end
    end
endmodule

// File: rtl/fnd_modulus_ctrl.sv
module fnd_modulus_ctrl #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 12,
    parameter int LFSR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [INT_W-1:0]  int_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic [FRAC_W-1:0] mod_val,
    input  logic [2:0]        noise_mode,
    input  logic              cnt_rst,
    input  logic              pwr_dn,
    output logic [INT_W:0]    div_val,
    output logic              carry,
    output logic              frac_err
);
    import fnd_pkg::*;

    fnd_state_e state_q, state_d;
    logic clr_acc, reseed, step_en, lfsr_adv;
    logic dith_bit, dith_on, dither_pend;
    logic [FRAC_W-1:0] frac_c, mod_q;
    logic [INT_W-1:0]  int_q;

    always_comb begin
        if (pwr_dn)       state_d = ST_OFF;
        else if (cnt_rst) state_d = ST_HOLD;
        else              state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        clr_acc = 1'b0;
        reseed  = 1'b0;
        step_en = 1'b0;
        unique case (state_d)
            ST_OFF:  clr_acc = 1'b1;
            ST_HOLD: begin
                clr_acc = 1'b1;
                reseed  = 1'b1;
            end
            ST_RUN:  step_en = ref_tick && (state_q == ST_RUN);
            default: clr_acc = 1'b1;
        endcase
        lfsr_adv = step_en;
    end

    fnd_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (ref_tick),
        .int_in       (int_val),
        .frac_in      (frac_val),
        .mod_in       (mod_val),
        .frac_clamped (frac_c),
        .int_q        (int_q),
        .mod_q        (mod_q),
        .err_q        (frac_err)
    );

    fnd_lfsr #(.W(LFSR_W), .TAP_A(LFSR_W-1), .TAP_B(LFSR_W-2)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .advance (lfsr_adv),
        .bit_o   (dith_bit)
    );

    assign dith_on = (noise_mode == MODE_LOW_SPUR) && (frac_c != '0) && (frac_c != mod_val);

    fnd_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr_acc),
        .step    (step_en),
        .frac    (frac_c),
        .modulus (mod_val),
        .dith    (dith_on & dith_bit),
        .carry_o (carry),
        .pend_o  (dither_pend)
    );

    assign div_val = {1'b0, int_q} + {{INT_W{1'b0}}, carry};

    logic unused_mod;
    assign unused_mod = ^mod_q;
endmodule

// File: rtl/fnd_modulus_ctrl_chk.sv
module fnd_modulus_ctrl_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic [FRAC_W-1:0] frac_val,
    input logic [FRAC_W-1:0] mod_val,
    input logic [2:0]        noise_mode,
    input logic              cnt_rst,
    input logic              pwr_dn,
    input logic [INT_W:0]    div_val,
    input logic              carry,
    input logic              frac_err,
    input logic              pend
);
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !cnt_rst && !pwr_dn) |=> ($stable(div_val) && $stable(carry) && $stable(frac_err)));

    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (!carry && !pend));

    a_r9_powerdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!carry && !pend));

    a_r11_zero_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && mod_val == '0) |=> !carry);

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && frac_val > mod_val) |=> frac_err);

    a_r7_no_dither: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && noise_mode != 3'b000) |=> !pend);
endmodule

bind fnd_modulus_ctrl fnd_modulus_ctrl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .frac_val   (frac_val),
    .mod_val    (mod_val),
    .noise_mode (noise_mode),
    .cnt_rst    (cnt_rst),
    .pwr_dn     (pwr_dn),
    .div_val    (div_val),
    .carry      (carry),
    .frac_err   (frac_err),
    .pend       (dither_pend)
);

// File: tb/fnd_modulus_ctrl_tb.sv
module fnd_modulus_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic [7:0] int_val = '0;
    logic [11:0] frac_val = '0, mod_val = '0;
    logic [2:0] noise_mode = 3'b001;
    logic cnt_rst = 1'b0, pwr_dn = 1'b0;
    logic [8:0] div_val;
    logic carry, frac_err;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    fnd_modulus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .int_val(int_val),
        .frac_val(frac_val), .mod_val(mod_val), .noise_mode(noise_mode),
        .cnt_rst(cnt_rst), .pwr_dn(pwr_dn), .div_val(div_val),
        .carry(carry), .frac_err(frac_err));

    // Behavioural reference model
    int m_acc, m_pend, m_int, m_frac, m_mod, m_carry, m_err, m_prev_run;
    logic [14:0] m_lfsr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_pend = 0; m_int = 0; m_frac = 0; m_mod = 0;
            m_carry = 0; m_err = 0; m_prev_run = 0; m_lfsr = 15'd1;
        end else begin
            int d, a, s, f, md;
            f = int'(frac_val); md = int'(mod_val);
            if (f > md) f = md;
            if (ref_tick) begin
                m_int = int'(int_val); m_err = (frac_val > mod_val) ? 1 : 0;
                m_frac = f; m_mod = md;
            end
            if (pwr_dn) begin
                m_acc = 0; m_pend = 0; m_carry = 0; m_prev_run = 0;
            end else if (cnt_rst) begin
                m_acc = 0; m_pend = 0; m_carry = 0; m_lfsr = 15'd1; m_prev_run = 0;
            end else begin
                if (ref_tick && m_prev_run != 0) begin
                    d = (noise_mode == 3'b000 && f != 0 && f != md) ? int'(m_lfsr[0]) : 0;
                    a = (m_acc >= md) ? 0 : m_acc;
                    s = a + f + d - m_pend;
                    if (s < 0) s = 0;
                    if (md != 0 && s >= md) begin m_carry = 1; s = s - md; end
                    else m_carry = 0;
                    m_acc = s; m_pend = d;
                    m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
                end
                m_prev_run = 1;
            end
        end
    end

    // Per-clock comparison (R2 covers div_val composition throughout)
    always @(negedge clk) begin
        if (!done) begin
            int exp_div;
            exp_div = m_int + m_carry;
            checks++;
            if (int'(div_val) != exp_div || int'(carry) != m_carry || int'(frac_err) != m_err) begin
                errors++;
                $display("FAIL %s/R2: div=%0d carry=%0d err=%0d expected div=%0d carry=%0d err=%0d",
                         cur_req, div_val, carry, frac_err, exp_div, m_carry, m_err);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tick then one idle cycle; returns carry seen after the tick edge
    task automatic do_tick(output int c);
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        c = int'(carry);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n, output int carries);
        carries = 0;
        for (int i = 0; i < n; i++) begin
            int c;
            do_tick(c);
            carries += c;
        end
    endtask

    task automatic setcfg(input int iv, input int fv, input int mv, input logic [2:0] md);
        @(negedge clk);
        int_val = 8'(iv); frac_val = 12'(fv); mod_val = 12'(mv); noise_mode = md;
    endtask

    initial begin
        int n;
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 div", int'(div_val), 0);
        check("R1 carry", int'(carry), 0);
        check("R1 err", int'(frac_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R3";
        setcfg(40, 3, 10, 3'b001);
        do_tick(n);                 // prime captured settings
        run_ticks(10, n);
        check("R3 carries in MOD ticks", n, 3);
        setcfg(100, 7, 16, 3'b001);
        do_tick(n);
        run_ticks(16, n);
        check("R3 carries in MOD ticks", n, 7);

        cur_req = "R4";
        @(negedge clk);
        int_val = 8'd5; frac_val = 12'd1; mod_val = 12'd2;
        repeat (4) @(negedge clk);
        check("R4 div unchanged between ticks", int'(div_val), 100 + int'(carry));
        check("R4 div before tick", int'(div_val) - int'(carry), 100);
        do_tick(n);
        check("R4 new int after tick", int'(div_val) - int'(carry), 5);

        cur_req = "R5";
        setcfg(20, 15, 10, 3'b001);
        run_ticks(4, n);
        check("R5 flag", int'(frac_err), 1);
        check("R5 clamped carries", n, 4);
        setcfg(20, 4, 10, 3'b001);
        do_tick(n);
        check("R5 flag cleared", int'(frac_err), 0);

        cur_req = "R6";
        setcfg(60, 5, 16, 3'b000);
        run_ticks(60, n);
        setcfg(60, 333, 1000, 3'b000);
        run_ticks(80, n);

        cur_req = "R7";
        setcfg(30, 7, 9, 3'b111);
        run_ticks(9, n);
        run_ticks(9, n);
        check("R7 lowest-noise carries", n, 7);
        setcfg(30, 7, 9, 3'b010);
        run_ticks(18, n);

        cur_req = "R8";
        setcfg(50, 9, 13, 3'b000);
        run_ticks(5, n);
        @(negedge clk); cnt_rst = 1'b1;
        do_tick(n);
        check("R8 carry held", int'(carry), 0);
        @(negedge clk); cnt_rst = 1'b0;
        cur_req = "R10";
        ref_tick = 1'b1;            // tick coincides with release edge
        @(negedge clk); ref_tick = 1'b0;
        check("R10 release tick no carry", int'(carry), 0);
        run_ticks(30, n);

        cur_req = "R9";
        @(negedge clk); pwr_dn = 1'b1; cnt_rst = 1'b1;
        do_tick(n);
        check("R9 carry held", int'(carry), 0);
        @(negedge clk); cnt_rst = 1'b0;
        repeat (3) @(negedge clk);
        pwr_dn = 1'b0;
        run_ticks(30, n);

        cur_req = "R11";
        setcfg(70, 0, 0, 3'b000);
        run_ticks(6, n);
        check("R11 zero modulus carries", n, 0);
        setcfg(70, 990, 1000, 3'b001);
        run_ticks(5, n);
        setcfg(70, 2, 5, 3'b001);
        run_ticks(10, n);
        setcfg(70, 0, 7, 3'b000);
        run_ticks(4, n);
        check("R11 integer mode carries", n, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule